// File: doc/BRIEF.md
# Serial Receive Character Store

This block is the receive-side character store of one serial channel. A deserializer hands it whole characters, one per cycle on a valid strobe. Each character comes with its raw data bits, the received parity bit and a flag that says whether a stop bit was seen. The block masks the character to the programmed length. It checks parity against the programmed mode and classifies break and framing conditions. Each character is kept together with its own error bits.

Up to four characters are held. Three of them sit in a FIFO and one sits in a stage that stands for the receive shift register. A host pops characters through a read strobe. It sees a six-bit status word and one interrupt line. Command strobes enable the receiver, disable it, reset it, and clear the error state. Bit sampling, baud generation and the transmitter belong to other blocks.

Top module: `uart_rx_hold_fifo`

## Requirements
- R1: The block holds at most 4 characters (FIFO_DEPTH = 3 plus one shift stage) and returns them in arrival order.
- R2: A character accepted while 4 are held and no pop happens in that cycle replaces the newest held character and sets overrun (status_o[2]). Overrun stays set until an error reset or a receiver reset.
- R3: status_o[0] (ready) is 1 when at least 1 character is held. status_o[1] (full) is 1 when at least 3 are held.
- R4: In character error mode (cfg_block_err_i = 0), status_o[5] (break), status_o[4] (framing) and status_o[3] (parity) show the error bits of the character at the FIFO head. They are 0 when nothing is held.
- R5: In character error mode, the error bits of a character leave the status once that character is popped. The status then shows the bits of the next character.
- R6: In block error mode (cfg_block_err_i = 1), status_o[5:3] is the OR of the error bits of every character accepted since the last error reset or receiver reset. Pops do not clear it.
- R7: A character with no stop bit whose masked data is zero is a break: only the break bit is set. A character with no stop bit and nonzero masked data sets only the framing bit. The parity bit may be set only for a character that is not a break.
- R8: cfg_len_i encodes 5, 6, 7 or 8 data bits (codes 0 to 3). Data is right-aligned and the unused upper bits are returned as 0. cfg_par_mode_i is decoded as follows:
  - code 0: parity is checked. The expected parity bit is the XOR of the masked data, XOR cfg_par_odd_i.
  - code 1: the parity bit is forced. It must equal cfg_par_odd_i.
  - codes 2 and 3: no parity error is ever flagged.
- R9: rx_irq_o follows the ready status when cfg_irq_full_i = 0 and the full status when cfg_irq_full_i = 1.
- R10: A receiver reset empties the store, clears overrun and all error bits, and disables the receiver. The enable and disable strobes set and clear rx_en_o; disable wins when both are strobed together. The reset state is disabled and empty, with rd_data_o = 0.
- R11: A pop while the store is empty leaves rd_data_o and the status unchanged.
- R12: A character offered while rx_en_o is 0 is dropped and leaves the status unchanged.
- R13: An error reset clears overrun and all held and accumulated error bits, and keeps the held characters.
- R14: On a pop of a held character, rd_data_o shows that character from the clock edge that samples rd_i onward, and the count drops at the same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rx_enable_i | input | 1 | Strobe: enable receiver |
| rx_disable_i | input | 1 | Strobe: disable receiver |
| rx_reset_i | input | 1 | Strobe: receiver reset |
| err_reset_i | input | 1 | Strobe: clear overrun and error bits |
| cfg_len_i | input | 2 | Character length code |
| cfg_par_mode_i | input | 2 | Parity mode code |
| cfg_par_odd_i | input | 1 | Parity type / forced parity value |
| cfg_block_err_i | input | 1 | 0 = character error mode, 1 = block error mode |
| cfg_irq_full_i | input | 1 | Interrupt source: 0 = ready, 1 = full |
| char_valid_i | input | 1 | Deserializer delivers a character |
| char_data_i | input | 8 | Raw character bits, LSB first bit |
| char_par_i | input | 1 | Received parity bit |
| char_stop_ok_i | input | 1 | Stop bit was seen |
| rd_i | input | 1 | Host pop strobe |
| rd_data_o | output | 8 | Last popped character |
| status_o | output | 6 | {break, framing, parity, overrun, full, ready} |
| rx_irq_o | output | 1 | Receive interrupt |
| rx_en_o | output | 1 | Receiver enabled |

## Verification
Every stored result is registered once. A character, a command or a pop driven before a rising edge shows in status_o, rx_en_o and rd_data_o right after that edge. rx_irq_o follows status and the configuration with no extra delay. The bench therefore drives on the falling edge, lets one rising edge pass, and compares on the next falling edge. For the interrupt select, it compares a short delay after changing only the configuration. A near-exhaustive sweep covers every length, parity mode, parity type, stop condition and a spread of data values, computing the expected error bits and masked data arithmetically. Fill sweeps of one to five characters check the thresholds, the order and the overrun replacement.

// File: rtl/uart_rxh_pkg.sv
`timescale 1ns/1ps
package uart_rxh_pkg;
  localparam int CHAR_W = 8;

  typedef enum logic [1:0] {
    PAR_CHECK = 2'd0,
    PAR_FORCE = 2'd1,
    PAR_NONE  = 2'd2,
    PAR_MDROP = 2'd3
  } par_mode_e;

  typedef struct packed {
    logic brk;
    logic fe;
    logic pe;
  } rx_err_t;

  typedef struct packed {
    logic [CHAR_W-1:0] data;
    rx_err_t           err;
  } rx_slot_t;
endpackage

// File: rtl/rxh_char_check.sv
`timescale 1ns/1ps
module rxh_char_check
  import uart_rxh_pkg::*;
(
  input  logic [1:0]        len_i,
  input  par_mode_e         par_mode_i,
  input  logic              par_odd_i,
  input  logic [CHAR_W-1:0] data_i,
  input  logic              par_bit_i,
  input  logic              stop_ok_i,
  output rx_slot_t          slot_o
);
  logic [CHAR_W-1:0] mask, masked;
  logic              par_calc, pe_raw, is_brk;

  always_comb begin
    for (int b = 0; b < CHAR_W; b++) mask[b] = (b < 5 + int'(len_i));
  end

  assign masked   = data_i & mask;
  assign par_calc = ^masked;
  assign is_brk   = !stop_ok_i && (masked == '0);

  always_comb begin
    unique case (par_mode_i)
      PAR_CHECK: pe_raw = (par_bit_i != (par_calc ^ par_odd_i));
      PAR_FORCE: pe_raw = (par_bit_i != par_odd_i);
      default:   pe_raw = 1'b0;
    endcase
  end

  assign slot_o.data    = masked;
  assign slot_o.err.brk = is_brk;
  assign slot_o.err.fe  = !stop_ok_i && !is_brk;
  assign slot_o.err.pe  = pe_raw && !is_brk;
endmodule

// File: rtl/rxh_queue.sv
`timescale 1ns/1ps
module rxh_queue
  import uart_rxh_pkg::*;
#(
  parameter int FIFO_DEPTH = 3,
  localparam int SLOTS = FIFO_DEPTH + 1,
  localparam int CNT_W = $clog2(SLOTS + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             flush_i,
  input  logic             clr_err_i,
  input  logic             push_i,
  input  rx_slot_t         slot_i,
  input  logic             pop_i,
  output rx_slot_t         head_o,
  output logic [CNT_W-1:0] cnt_o,
  output logic             ovr_evt_o
);
  localparam logic [CNT_W-1:0] SLOTS_C = CNT_W'(SLOTS);

  rx_slot_t         slot_q [SLOTS];
  rx_slot_t         slot_n [SLOTS];
  logic [CNT_W-1:0] cnt_q, cnt_pop, cnt_n, wr_idx;
  logic             pop_ok;

  assign pop_ok    = pop_i && (cnt_q != '0);
  assign cnt_pop   = cnt_q - CNT_W'(pop_ok);
  // last slot is the shift stage: overwritten when everything is occupied
  assign wr_idx    = (cnt_pop >= SLOTS_C) ? SLOTS_C - 1'b1 : cnt_pop;
  assign ovr_evt_o = push_i && (cnt_pop == SLOTS_C);
  assign cnt_n     = cnt_pop + CNT_W'(push_i && (cnt_pop < SLOTS_C));

  always_comb begin
    for (int i = 0; i < SLOTS; i++) begin
      slot_n[i] = pop_ok ? slot_q[(i < SLOTS - 1) ? i + 1 : i] : slot_q[i];
      if (clr_err_i) slot_n[i].err = '0;
      if (push_i && (wr_idx == CNT_W'(i))) slot_n[i] = slot_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      for (int i = 0; i < SLOTS; i++) slot_q[i] <= '0;
    end else if (flush_i) begin
      cnt_q <= '0;
      for (int i = 0; i < SLOTS; i++) slot_q[i].err <= '0;
    end else begin
      cnt_q <= cnt_n;
      for (int i = 0; i < SLOTS; i++) slot_q[i] <= slot_n[i];
    end
  end

  assign head_o = slot_q[0];
  assign cnt_o  = cnt_q;

  a_r1_cnt_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= SLOTS_C);

  a_r2_overrun_stays_full: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ovr_evt_o && !flush_i) |=> (cnt_q == SLOTS_C));
endmodule

// File: rtl/uart_rx_hold_fifo.sv
`timescale 1ns/1ps
module uart_rx_hold_fifo
  import uart_rxh_pkg::*;
#(
  parameter int FIFO_DEPTH = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rx_enable_i,
  input  logic              rx_disable_i,
  input  logic              rx_reset_i,
  input  logic              err_reset_i,
  input  logic [1:0]        cfg_len_i,
  input  logic [1:0]        cfg_par_mode_i,
  input  logic              cfg_par_odd_i,
  input  logic              cfg_block_err_i,
  input  logic              cfg_irq_full_i,
  input  logic              char_valid_i,
  input  logic [CHAR_W-1:0] char_data_i,
  input  logic              char_par_i,
  input  logic              char_stop_ok_i,
  input  logic              rd_i,
  output logic [CHAR_W-1:0] rd_data_o,
  output logic [5:0]        status_o,
  output logic              rx_irq_o,
  output logic              rx_en_o
);
  localparam int SLOTS = FIFO_DEPTH + 1;
  localparam int CNT_W = $clog2(SLOTS + 1);
  localparam logic [CNT_W-1:0] FULL_C  = CNT_W'(FIFO_DEPTH);
  localparam logic [CNT_W-1:0] SLOTS_C = CNT_W'(SLOTS);

  rx_slot_t          new_slot, head;
  rx_err_t           acc_q, err_shown;
  logic [CNT_W-1:0]  cnt;
  logic [CHAR_W-1:0] rd_data_q;
  logic              rx_en_q, ovr_q, accept, ovr_evt, ready, full;

  rxh_char_check i_check (
    .len_i      (cfg_len_i),
    .par_mode_i (par_mode_e'(cfg_par_mode_i)),
    .par_odd_i  (cfg_par_odd_i),
    .data_i     (char_data_i),
    .par_bit_i  (char_par_i),
    .stop_ok_i  (char_stop_ok_i),
    .slot_o     (new_slot)
  );

  assign accept = char_valid_i && rx_en_q && !rx_reset_i;

  rxh_queue #(.FIFO_DEPTH(FIFO_DEPTH)) i_queue (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .flush_i   (rx_reset_i),
    .clr_err_i (err_reset_i),
    .push_i    (accept),
    .slot_i    (new_slot),
    .pop_i     (rd_i),
    .head_o    (head),
    .cnt_o     (cnt),
    .ovr_evt_o (ovr_evt)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rx_en_q   <= 1'b0;
      ovr_q     <= 1'b0;
      acc_q     <= '0;
      rd_data_q <= '0;
    end else if (rx_reset_i) begin
      rx_en_q <= 1'b0;
      ovr_q   <= 1'b0;
      acc_q   <= '0;
    end else begin
      if (rx_disable_i)     rx_en_q <= 1'b0;
      else if (rx_enable_i) rx_en_q <= 1'b1;
      ovr_q <= (ovr_q && !err_reset_i) || ovr_evt;
      acc_q <= (err_reset_i ? rx_err_t'('0) : acc_q) | (accept ? new_slot.err : rx_err_t'('0));
      if (rd_i && (cnt != '0)) rd_data_q <= head.data;
    end
  end

  assign ready     = (cnt != '0);
  assign full      = (cnt >= FULL_C);
  assign err_shown = cfg_block_err_i ? acc_q : (ready ? head.err : rx_err_t'('0));

  assign status_o  = {err_shown.brk, err_shown.fe, err_shown.pe, ovr_q, full, ready};
  assign rx_irq_o  = cfg_irq_full_i ? full : ready;
  assign rx_en_o   = rx_en_q;
  assign rd_data_o = rd_data_q;

  a_r3_full_has_ready: assert property (@(posedge clk_i) disable iff (!rst_ni)
    status_o[1] |-> status_o[0]);

  a_r2_overrun_flag: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (char_valid_i && rx_en_o && !rx_reset_i && !rd_i && (cnt == SLOTS_C)) |=> status_o[2]);

  a_r10_rx_reset_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_reset_i |=> (status_o == 6'd0) && !rx_en_o);

  a_r11_empty_read_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && !status_o[0]) |=> $stable(rd_data_o));

  a_r12_disabled_drop: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (char_valid_i && !rx_en_o && !rd_i && !rx_reset_i && !err_reset_i) |=> $stable(status_o[2:0]));

  a_r13_err_reset_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (err_reset_i && !char_valid_i) |=> (status_o[5:2] == 4'd0));
endmodule

// File: tb/test_uart_rx_hold_fifo.sv
`timescale 1ns/1ps
module test_uart_rx_hold_fifo;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       rx_enable_i = 0, rx_disable_i = 0, rx_reset_i = 0, err_reset_i = 0;
  logic [1:0] cfg_len_i = 2'd3, cfg_par_mode_i = 2'd2;
  logic       cfg_par_odd_i = 0, cfg_block_err_i = 0, cfg_irq_full_i = 0;
  logic       char_valid_i = 0, char_par_i = 0, char_stop_ok_i = 1;
  logic [7:0] char_data_i = 0;
  logic       rd_i = 0;
  logic [7:0] rd_data_o;
  logic [5:0] status_o;
  logic       rx_irq_o, rx_en_o;

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #4 clk_i = ~clk_i;

  uart_rx_hold_fifo i_uart_rx_hold_fifo (.*);

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic cyc();
    @(posedge clk_i);
    @(negedge clk_i);
  endtask

  task automatic push(input logic [7:0] d, input logic p, input logic s);
    char_valid_i = 1; char_data_i = d; char_par_i = p; char_stop_ok_i = s;
    cyc();
    char_valid_i = 0;
  endtask

  task automatic pop();
    rd_i = 1; cyc(); rd_i = 0;
  endtask

  task automatic rx_rst();
    rx_reset_i = 1; cyc(); rx_reset_i = 0;
  endtask

  task automatic err_rst();
    err_reset_i = 1; cyc(); err_reset_i = 0;
  endtask

  task automatic enable();
    rx_enable_i = 1; cyc(); rx_enable_i = 0;
  endtask

  function automatic logic [7:0] mask_of(input logic [1:0] len);
    return 8'((9'd1 << (5 + len)) - 1);
  endfunction

  // expected {brk, fe, pe}
  function automatic logic [2:0] exp_err(input logic [1:0] len, input logic [1:0] md,
                                         input logic odd, input logic [7:0] d,
                                         input logic p, input logic s);
    logic [7:0] m;
    logic brk, fe, pe;
    m   = d & mask_of(len);
    brk = !s && (m == 0);
    fe  = !s && (m != 0);
    pe  = 0;
    if (md == 2'd0) pe = (p != ((^m) ^ odd));
    else if (md == 2'd1) pe = (p != odd);
    if (brk) pe = 0;
    return {brk, fe, pe};
  endfunction

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog act=0 exp=1");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [7:0] d [5];
    repeat (3) @(negedge clk_i);
    rst_ni = 1;
    @(negedge clk_i);
    // reset state R10
    chk("R10 reset status", status_o, 0);
    chk("R10 reset enable", rx_en_o, 0);
    chk("R10 reset data", rd_data_o, 0);
    chk("R9 reset irq", rx_irq_o, 0);

    // R12: disabled receiver drops
    push(8'h5A, 0, 1);
    chk("R12 dropped status", status_o, 0);
    enable();
    chk("R10 enable", rx_en_o, 1);
    pop();
    chk("R12 nothing held data", rd_data_o, 0);

    // R4 R5 R7 R8 R14: classification sweep
    for (int len = 0; len < 4; len++)
      for (int md = 0; md < 4; md++)
        for (int odd = 0; odd < 2; odd++)
          for (int dv = 0; dv < 16; dv++)
            for (int p = 0; p < 2; p++)
              for (int s = 0; s < 2; s++) begin
                logic [7:0] dd;
                dd = (dv == 15) ? 8'hE0 : 8'(dv * 37);
                cfg_len_i = 2'(len); cfg_par_mode_i = 2'(md); cfg_par_odd_i = 1'(odd);
                push(dd, 1'(p), 1'(s));
                chk("R4 R7 R8 head error bits", status_o,
                    {exp_err(2'(len), 2'(md), 1'(odd), dd, 1'(p), 1'(s)), 3'b001});
                pop();
                chk("R8 R14 masked data", rd_data_o, dd & mask_of(2'(len)));
                chk("R5 empty after pop", status_o, 0);
              end

    // R1 R2 R3 R9: fill sweeps
    cfg_len_i = 3; cfg_par_mode_i = 2; cfg_par_odd_i = 0;
    for (int n = 1; n <= 5; n++) begin
      rx_rst();
      enable();
      for (int k = 0; k < n; k++) begin
        d[k] = 8'(8'h31 * (k + 1) + n);
        push(d[k], 0, 1);
        chk("R3 ready", status_o[0], 1);
        chk("R3 full", status_o[1], (k + 1) >= 3);
        chk("R2 overrun", status_o[2], (k + 1) >= 5);
        cfg_irq_full_i = 0; #1;
        chk("R9 irq ready", rx_irq_o, 1);
        cfg_irq_full_i = 1; #1;
        chk("R9 irq full", rx_irq_o, (k + 1) >= 3);
        cfg_irq_full_i = 0;
      end
      for (int j = 0; j < ((n > 4) ? 4 : n); j++) begin
        pop();
        chk("R1 R2 order", rd_data_o, (j < 3) ? d[j] : d[n - 1]);
      end
      chk("R1 empty", status_o[1:0], 0);
      chk("R2 overrun sticky", status_o[2], n == 5);
      err_rst();
      chk("R13 overrun cleared", status_o, 0);
    end

    // R11: empty read
    pop();
    chk("R11 data unchanged", rd_data_o, d[4]);
    chk("R11 status unchanged", status_o, 0);

    // R1: pop and push at full -> no overrun
    for (int k = 0; k < 4; k++) push(8'(k + 1), 0, 1);
    rd_i = 1; char_valid_i = 1; char_data_i = 8'h77; char_stop_ok_i = 1;
    cyc();
    rd_i = 0; char_valid_i = 0;
    chk("R1 simultaneous data", rd_data_o, 1);
    chk("R1 no overrun", status_o[2:0], 3'b011);
    for (int k = 0; k < 4; k++) begin
      pop();
      chk("R1 order after swap", rd_data_o, (k < 3) ? k + 2 : 8'h77);
    end

    // R5: character mode discards per character
    rx_rst(); enable();
    cfg_par_mode_i = 0; cfg_par_odd_i = 0; cfg_block_err_i = 0;
    push(8'h03, 1, 1);   // even parity expects 0 -> error
    push(8'h03, 0, 1);
    chk("R5 head pe", status_o[5:3], 3'b001);
    pop();
    chk("R5 next clean", status_o[5:3], 0);

    // R6: block mode accumulates
    rx_rst(); enable();
    cfg_block_err_i = 1;
    push(8'h03, 1, 1);   // parity
    push(8'h01, 1, 0);   // framing, parity ok
    push(8'h00, 0, 0);   // break
    pop(); pop();
    chk("R6 accumulated", status_o[5:3], 3'b111);
    pop();
    chk("R6 kept after empty", status_o, 6'b111000);
    err_rst();
    chk("R6 R13 cleared", status_o, 0);

    // R13: error reset keeps characters
    cfg_block_err_i = 0;
    push(8'h03, 1, 1);
    push(8'h05, 0, 1);
    err_rst();
    chk("R13 chars kept", status_o, 6'b000001);
    pop();
    chk("R13 data kept", rd_data_o, 8'h03);

    // R10: receiver reset
    push(8'h44, 0, 1);
    push(8'h00, 0, 0);
    rx_rst();
    chk("R10 flushed", status_o, 0);
    chk("R10 disabled", rx_en_o, 0);
    push(8'h12, 0, 1);
    chk("R12 dropped after reset", status_o, 0);
    rx_enable_i = 1; rx_disable_i = 1; cyc(); rx_enable_i = 0; rx_disable_i = 0;
    chk("R10 disable wins", rx_en_o, 0);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule